// File: doc/BRIEF.md
# Receive Idle Flush Controller

This block decides when bytes waiting in a receive buffer must be handed to the host-side packet builder even though a full packet has not collected. A millisecond timer counts ticks from a 1 ms strobe and restarts whenever a byte is written into the buffer, whenever the buffer reports a full packet, and whenever a flush request is acknowledged. When the timer reaches the active timeout while the buffer holds at least one byte, the block raises a flush request. The request stays up until the packet builder acknowledges it.

The timeout comes from an 8-bit register with a write port. It holds 16 after reset and accepts values from 1 to 255 in 1 ms steps. A written 0 is stored as 1. A value written to the register is copied into the active limit only when the timer next restarts. A write therefore never shortens or stretches the interval that is already running.

Control is a three-state machine. TIMING is the state in which the timer runs. HOLD means the limit has been reached with an empty buffer. FLUSH means the request is up. The transitions are as follows. TIMING moves to FLUSH when the limit is reached with data present, and to HOLD when the limit is reached with the buffer empty. HOLD moves to FLUSH when data appears, and back to TIMING on a restart. FLUSH returns to TIMING on an acknowledge. Any restart in TIMING keeps the machine in TIMING.

Top module: `rx_idle_flush_ctrl`

## Requirements
- R1: After reset `flush_req` is 0 and the timeout is 16 ms. With ticks on every cycle, `flush_req` rises on the 17th rising edge after the edge that takes a byte write.
- R2: Every byte write (`fifo_wr`=1) clears the timer to zero, so writes spaced closer than the timeout never cause a request.
- R3: In TIMING, when the count equals the active limit, no restart is present and `fifo_level` is non-zero, `flush_req` rises on that edge. The count advances by one only on edges where `ms_tick`=1.
- R4: No request is raised while `fifo_level`=0. If data appears after the limit has been reached, `flush_req` rises on the next edge.
- R5: `flush_req` stays 1 until an edge with `flush_ack`=1. On that edge it drops and the timer restarts from zero. `flush_ack` has no effect while `flush_req` is 0.
- R6: A write of 0 through `cfg_we`/`cfg_wdata` is stored as 1 ms.
- R7: A newly written timeout becomes the active limit only at the next timer restart (byte write, full packet or acknowledge).
- R8: `pkt_full`=1 clears the timer without raising a flush request.
- R9: Any timeout from 1 to 255 ms is honoured in 1 ms steps. With ticks on every cycle, a limit of L gives a request L+1 edges after the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| fifo_wr | input | 1 | A byte is written into the receive buffer |
| fifo_level | input | LVL_W | Bytes currently held in the receive buffer |
| pkt_full | input | 1 | The buffer has collected a full packet |
| flush_ack | input | 1 | The packet builder accepts the flush |
| cfg_we | input | 1 | Write strobe for the timeout register |
| cfg_wdata | input | CFG_W | Timeout value in ms |
| flush_req | output | 1 | Request to send the partial buffer |

## Verification
The bench builds the block with an 8-bit timeout register, a default of 16 and a 4-bit level input. With these values the extreme limits of 1 and 255 can be reached within a few hundred cycles, and the all-ones buffer level can be driven. Ticks are driven both on every cycle and sparsely, so the bench sees the difference between the passing of cycles and the passing of milliseconds. Writes to the timeout register are placed in the middle of a running interval, which exposes any register value that takes effect too early.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        ST_TIMING = 2'd0,
        ST_HOLD   = 2'd1,
        ST_FLUSH  = 2'd2
    } rxf_state_e;
endpackage

// File: rtl/rxf_cfg_reg.sv
module rxf_cfg_reg #(
    parameter int CFG_W      = 8,
    parameter int DEFAULT_MS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_val
);
    localparam logic [CFG_W-1:0] RESET_VAL = CFG_W'(DEFAULT_MS);
    localparam logic [CFG_W-1:0] MIN_VAL   = CFG_W'(1);

    logic [CFG_W-1:0] wr_clamped;

    always_comb begin
        wr_clamped = (cfg_wdata == '0) ? MIN_VAL : cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_val <= RESET_VAL;
        end else if (cfg_we) begin
            cfg_val <= wr_clamped;
        end
    end

    assert_zero_write_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata == '0) |=> (cfg_val == MIN_VAL));

    assert_cfg_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_val != '0);
endmodule

// File: rtl/rxf_ms_timer.sv
module rxf_ms_timer #(
    parameter int CFG_W      = 8,
    parameter int DEFAULT_MS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             ms_tick,
    input  logic [CFG_W-1:0] cfg_val,
    output logic             expired
);
    localparam logic [CFG_W-1:0] RESET_LIM = CFG_W'(DEFAULT_MS);

    logic [CFG_W-1:0] ms_cnt;
    logic [CFG_W-1:0] act_lim;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lim <= RESET_LIM;
        end else if (restart) begin
            act_lim <= cfg_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_cnt <= '0;
        end else if (restart) begin
            ms_cnt <= '0;
        end else if (ms_tick && (ms_cnt < act_lim)) begin
            ms_cnt <= ms_cnt + CFG_W'(1);
        end
    end

    always_comb begin
        expired = (ms_cnt == act_lim);
    end

    assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ms_cnt == '0));

    assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt <= act_lim);

    assert_no_tick_no_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !restart) |=> $stable(ms_cnt));

    assert_limit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(act_lim));
endmodule

// File: rtl/rxf_flush_fsm.sv
module rxf_flush_fsm #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expired,
    input  logic             restart,
    input  logic             flush_ack,
    input  logic             pkt_full,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             flush_req
);
    import rxf_pkg::*;

    rxf_state_e state_q, state_d;
    logic       has_data;

    always_comb begin
        has_data = (fifo_level != '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TIMING: begin
                if (restart)               state_d = ST_TIMING;
                else if (expired && has_data) state_d = ST_FLUSH;
                else if (expired)          state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (restart)               state_d = ST_TIMING;
                else if (has_data)         state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (flush_ack)             state_d = ST_TIMING;
            end
            default:                       state_d = ST_TIMING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TIMING;
        else        state_q <= state_d;
    end

    always_comb begin
        flush_req = (state_q == ST_FLUSH);
    end

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);

    assert_ack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_ack) |=> !flush_req);

    assert_rise_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(fifo_level != '0));

    assert_rise_needs_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(expired && !restart));

    assert_full_no_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_full && !flush_req) |=> !flush_req);
endmodule

// File: rtl/rx_idle_flush_ctrl.sv
module rx_idle_flush_ctrl #(
    parameter int CFG_W      = 8,
    parameter int LVL_W      = 7,
    parameter int DEFAULT_MS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             fifo_wr,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             pkt_full,
    input  logic             flush_ack,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             flush_req
);
    logic [CFG_W-1:0] cfg_val;
    logic             expired;
    logic             restart;

    always_comb begin
        restart = fifo_wr | pkt_full | (flush_req & flush_ack);
    end

    rxf_cfg_reg #(.CFG_W(CFG_W), .DEFAULT_MS(DEFAULT_MS)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_val   (cfg_val)
    );

    rxf_ms_timer #(.CFG_W(CFG_W), .DEFAULT_MS(DEFAULT_MS)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ms_tick (ms_tick),
        .cfg_val (cfg_val),
        .expired (expired)
    );

    rxf_flush_fsm #(.LVL_W(LVL_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .expired    (expired),
        .restart    (restart),
        .flush_ack  (flush_ack),
        .pkt_full   (pkt_full),
        .fifo_level (fifo_level),
        .flush_req  (flush_req)
    );

    assert_byte_write_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !flush_req) |=> !flush_req);
endmodule

// File: tb/rx_idle_flush_ctrl_tb.sv
`timescale 1ns/1ps
module rx_idle_flush_ctrl_tb_top;
    localparam int CFG_W = 8;
    localparam int LVL_W = 4;
    localparam int DEF   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, fifo_wr = 1'b0, pkt_full = 1'b0, flush_ack = 1'b0, cfg_we = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic flush_req;

    int vectors = 0;
    int miscompares = 0;
    string phase = "R1";
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_idle_flush_ctrl #(.CFG_W(CFG_W), .LVL_W(LVL_W), .DEFAULT_MS(DEF)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fifo_wr(fifo_wr),
        .fifo_level(fifo_level), .pkt_full(pkt_full), .flush_ack(flush_ack),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .flush_req(flush_req)
    );

    // Behavioural reference: timeout register, active limit, elapsed ms, request.
    int  m_cfg, m_lim, m_cnt;
    bit  m_req;

    always @(posedge clk) begin
        bit rs, nreq;
        if (!rst_n) begin
            m_cfg = DEF; m_lim = DEF; m_cnt = 0; m_req = 1'b0;
        end else begin
            rs   = fifo_wr || pkt_full || (m_req && flush_ack);
            nreq = m_req ? !flush_ack
                         : (!rs && m_cnt == m_lim && fifo_level != 0);
            if (rs) begin
                m_cnt = 0;
                m_lim = m_cfg;
            end else if (ms_tick && m_cnt < m_lim) begin
                m_cnt = m_cnt + 1;
            end
            if (cfg_we) m_cfg = (cfg_wdata == 0) ? 1 : int'(cfg_wdata);
            m_req = nreq;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            if (flush_req !== m_req) begin
                miscompares++;
                $display("FAIL %s: flush_req actual %0b expected %0b at %0t",
                         phase, flush_req, m_req, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick_run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            ms_tick = (gap == 0) ? 1'b1 : ((i % gap) == 0);
            @(negedge clk);
        end
        ms_tick = 1'b0;
    endtask

    task automatic pulse_wr();
        fifo_wr = 1'b1;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic do_ack();
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
    endtask

    task automatic cfg_write(input int v);
        cfg_we = 1'b1;
        cfg_wdata = CFG_W'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Restart with a byte write, then tick every cycle until the request rises.
    task automatic measure(input int exp, input string tag);
        int n;
        pulse_wr();
        ms_tick = 1'b1;
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            n++;
            if (flush_req) break;
        end
        ms_tick = 1'b0;
        chk(n == exp, tag, n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(flush_req == 1'b0, "R1", flush_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flush_req == 1'b0, "R1", flush_req, 0);

        phase = "R1";
        fifo_level = 4'd3;
        measure(DEF + 1, "R1");

        phase = "R5";
        tick_run(5, 0);
        chk(flush_req == 1'b1, "R5", flush_req, 1);
        do_ack();
        chk(flush_req == 1'b0, "R5", flush_req, 0);
        flush_ack = 1'b1;
        tick_run(3, 0);
        flush_ack = 1'b0;
        chk(flush_req == 1'b0, "R5", flush_req, 0);

        phase = "R2";
        for (int k = 0; k < 6; k++) begin
            pulse_wr();
            tick_run(10, 0);
        end
        chk(flush_req == 1'b0, "R2", flush_req, 0);

        phase = "R4";
        fifo_level = '0;
        pulse_wr();
        tick_run(40, 0);
        chk(flush_req == 1'b0, "R4", flush_req, 0);
        fifo_level = 4'd5;
        @(negedge clk);
        chk(flush_req == 1'b1, "R4", flush_req, 1);
        do_ack();

        phase = "R6";
        cfg_write(0);
        measure(2, "R6");
        do_ack();

        phase = "R9";
        cfg_write(255);
        measure(256, "R9");
        do_ack();
        cfg_write(1);
        measure(2, "R9");
        do_ack();

        phase = "R7";
        cfg_write(10);
        tick_run(2, 0);
        chk(flush_req == 1'b1, "R7", flush_req, 1);
        do_ack();
        measure(11, "R7");
        do_ack();

        phase = "R8";
        tick_run(7, 0);
        pkt_full = 1'b1;
        @(negedge clk);
        pkt_full = 1'b0;
        tick_run(7, 0);
        chk(flush_req == 1'b0, "R8", flush_req, 0);
        tick_run(4, 0);
        chk(flush_req == 1'b1, "R8", flush_req, 1);
        do_ack();

        phase = "R3";
        fifo_level = 4'hF;
        pulse_wr();
        tick_run(28, 3);
        chk(flush_req == 1'b0, "R3", flush_req, 0);
        @(negedge clk);
        chk(flush_req == 1'b1, "R3", flush_req, 1);
        do_ack();
        tick_run(5, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule